// File: doc/BRIEF.md
# Over-Temperature Guard Comparator

This block watches four filtered temperature sensing points and decides when the die is too hot. Each sensing point delivers a raw code with a valid strobe. The code runs on an inverted scale: a smaller code means a hotter point. A programmable offset is added to every accepted code, and the sum saturates at the largest code. The adjusted code is held per point. When a fresh sample arrives, the block picks the code to judge, either the hottest held point or one chosen point. It then compares that code with a raw trip level.

A trip drives a reboot request that no enable can mask. It also sets a sticky status flag. The flag feeds a stage-3 interrupt line through an enable bit. Software clears the flag by writing a one to it. A raw code of zero means that the sensor has no result yet, and the block drops it. A large offset therefore makes every point look very cold, which keeps the unmaskable reboot path quiet while the rest of the setup is being written.

The control word `guard_cfg` holds three fields. Bits 13:0 carry the offset. Bits 17:16 carry the selection mode. Bits 19:18 carry the point index used in single-point mode. Bits 15:14 are unused.

Top module: `otp_monitor`

## Requirements
- R1: A sample whose raw code is zero is dropped. It updates no held code and starts no evaluation, even when its valid strobe is high.
- R2: Each accepted code is stored as raw code plus the offset in `guard_cfg[13:0]`. The sum saturates at 2^CODE_W-1 and does not wrap. The offset in force at capture time is the one that is used.
- R3: Mode value 1 in `guard_cfg[17:16]` judges the smallest held adjusted code among all points that have ever delivered an accepted code. Any accepted sample from any point starts an evaluation.
- R4: Mode value 2 in `guard_cfg[17:16]` judges only the point whose index is in `guard_cfg[19:18]`. Only an accepted sample from that point starts an evaluation.
- R5: Mode values 0 and 3 start no evaluation. `reboot_req` and `alarm_status` keep their values.
- R6: An evaluation trips when the judged code is less than or equal to `trip_level`. `reboot_req` shows the result of the latest evaluation two clock edges after the sample's valid strobe, and it has no enable.
- R7: `alarm_status` is set by a tripping evaluation and stays set until a write with `status_wr`=1 and `status_wdata`=1. A write with `status_wdata`=0 has no effect. A trip in the same cycle as a clear leaves the flag set.
- R8: `alarm_irq` is high exactly when `alarm_status` and `alarm_en` are both high. `alarm_en` does not affect `reboot_req` or `alarm_status`.
- R9: After reset, `reboot_req`, `alarm_status` and `alarm_irq` are 0 and no point has a held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_code | input | NSENS*CODE_W | Filtered raw codes, point i in bits [i*CODE_W +: CODE_W] |
| sense_vld | input | NSENS | Per-point valid strobe |
| guard_cfg | input | 20 | Offset [13:0], mode [17:16], point index [19:18] |
| trip_level | input | CODE_W | Raw trip threshold |
| alarm_en | input | 1 | Stage-3 interrupt enable |
| status_wr | input | 1 | Status write strobe |
| status_wdata | input | 1 | Write-one-to-clear data for the status flag |
| reboot_req | output | 1 | Unmaskable reboot request |
| alarm_irq | output | 1 | Stage-3 interrupt line |
| alarm_status | output | 1 | Sticky stage-3 status flag |

## Verification
The comparison is swept over every mode value and every point index, three thresholds, three offsets and eight mixes of valid strobes and codes. The codes include zero, values near the threshold and values high enough to saturate. This separates a minimum taken over held points from one taken over the current strobes only, and a point-specific trigger from an any-point trigger. Directed cases pair a saturating sum with a threshold just below full scale, so a wrapping adder would trip where the correct design does not. They also let a trip and a clear land on the same edge, and they show that the interrupt enable gates only the interrupt line.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int unsigned CFG_W     = 20;
  localparam int unsigned OFS_LSB   = 0;
  localparam int unsigned OFS_W     = 14;
  localparam int unsigned MODE_LSB  = 16;
  localparam int unsigned IDX_LSB   = 18;
  localparam int unsigned IDX_W     = 2;

  typedef enum logic [1:0] {
    SEL_OFF = 2'd0,
    SEL_HOT = 2'd1,
    SEL_ONE = 2'd2,
    SEL_RSV = 2'd3
  } sel_mode_e;

  // Saturating add of two codes limited to w bits (w below 32).
  function automatic logic [31:0] sat_sum(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input int unsigned w);
    logic [32:0] s;
    logic [32:0] lim;
    s   = {1'b0, a} + {1'b0, b};
    lim = (33'd1 << w) - 33'd1;
    return (s > lim) ? lim[31:0] : s[31:0];
  endfunction

  function automatic sel_mode_e cfg_mode(input logic [CFG_W-1:0] cfg);
    return sel_mode_e'(cfg[MODE_LSB +: 2]);
  endfunction

  function automatic logic [IDX_W-1:0] cfg_index(input logic [CFG_W-1:0] cfg);
    return cfg[IDX_LSB +: IDX_W];
  endfunction

  function automatic logic [OFS_W-1:0] cfg_offset(input logic [CFG_W-1:0] cfg);
    return cfg[OFS_LSB +: OFS_W];
  endfunction

endpackage

// File: rtl/otp_sense_latch.sv
module otp_sense_latch
  import otp_pkg::*;
#(
  parameter int unsigned NSENS  = 4,
  parameter int unsigned CODE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSENS*CODE_W-1:0] sense_code,
  input  logic [NSENS-1:0]        sense_vld,
  input  logic [OFS_W-1:0]        offset,
  output logic [NSENS*CODE_W-1:0] held_code,
  output logic [NSENS-1:0]        held_ok,
  output logic [NSENS-1:0]        fresh
);

  for (genvar g = 0; g < NSENS; g++) begin : g_pt
    logic [CODE_W-1:0] raw;
    logic              accept;
    logic [31:0]       sum32;
    logic [CODE_W-1:0] adj;

    assign raw    = sense_code[g*CODE_W +: CODE_W];
    assign accept = sense_vld[g] && (raw != '0);
    assign sum32  = sat_sum(32'(raw), 32'(offset), CODE_W);
    assign adj    = sum32[CODE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_code[g*CODE_W +: CODE_W] <= '0;
        held_ok[g]                    <= 1'b0;
        fresh[g]                      <= 1'b0;
      end else begin
        fresh[g] <= accept;
        if (accept) begin
          held_code[g*CODE_W +: CODE_W] <= adj;
          held_ok[g]                    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/otp_eval.sv
module otp_eval
  import otp_pkg::*;
#(
  parameter int unsigned NSENS  = 4,
  parameter int unsigned CODE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  sel_mode_e               mode,
  input  logic [IDX_W-1:0]        index,
  input  logic [NSENS*CODE_W-1:0] held_code,
  input  logic [NSENS-1:0]        held_ok,
  input  logic [NSENS-1:0]        fresh,
  input  logic [CODE_W-1:0]       trip_level,
  output logic                    eval_fire,
  output logic                    trip_now,
  output logic                    reboot_req
);

  logic [CODE_W-1:0] code_arr [NSENS];
  logic [CODE_W-1:0] judged;

  for (genvar g = 0; g < NSENS; g++) begin : g_unpack
    assign code_arr[g] = held_code[g*CODE_W +: CODE_W];
  end

  always_comb begin
    eval_fire = 1'b0;
    judged    = '1;
    unique case (mode)
      SEL_HOT: begin
        eval_fire = |fresh;
        for (int i = 0; i < NSENS; i++) begin
          if (held_ok[i] && (code_arr[i] < judged)) judged = code_arr[i];
        end
      end
      SEL_ONE: begin
        eval_fire = fresh[index];
        judged    = code_arr[index];
      end
      default: begin
        eval_fire = 1'b0;
        judged    = '1;
      end
    endcase
  end

  assign trip_now = eval_fire && (judged <= trip_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reboot_req <= 1'b0;
    else if (eval_fire) reboot_req <= trip_now;
  end

endmodule

// File: rtl/otp_alarm.sv
module otp_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_now,
  input  logic status_wr,
  input  logic status_wdata,
  input  logic alarm_en,
  output logic alarm_status,
  output logic alarm_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          alarm_status <= 1'b0;
    else if (trip_now)                   alarm_status <= 1'b1;
    else if (status_wr && status_wdata)  alarm_status <= 1'b0;
  end

  assign alarm_irq = alarm_status & alarm_en;

endmodule

// File: rtl/otp_monitor.sv
module otp_monitor
  import otp_pkg::*;
#(
  parameter int unsigned NSENS  = 4,
  parameter int unsigned CODE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSENS*CODE_W-1:0] sense_code,
  input  logic [NSENS-1:0]        sense_vld,
  input  logic [CFG_W-1:0]        guard_cfg,
  input  logic [CODE_W-1:0]       trip_level,
  input  logic                    alarm_en,
  input  logic                    status_wr,
  input  logic                    status_wdata,
  output logic                    reboot_req,
  output logic                    alarm_irq,
  output logic                    alarm_status
);

  logic [NSENS*CODE_W-1:0] held_code;
  logic [NSENS-1:0]        held_ok;
  logic [NSENS-1:0]        fresh;
  logic                    eval_fire;
  logic                    trip_now;

  otp_sense_latch #(.NSENS(NSENS), .CODE_W(CODE_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_code (sense_code),
    .sense_vld  (sense_vld),
    .offset     (cfg_offset(guard_cfg)),
    .held_code  (held_code),
    .held_ok    (held_ok),
    .fresh      (fresh)
  );

  otp_eval #(.NSENS(NSENS), .CODE_W(CODE_W)) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (cfg_mode(guard_cfg)),
    .index      (cfg_index(guard_cfg)),
    .held_code  (held_code),
    .held_ok    (held_ok),
    .fresh      (fresh),
    .trip_level (trip_level),
    .eval_fire  (eval_fire),
    .trip_now   (trip_now),
    .reboot_req (reboot_req)
  );

  otp_alarm u_alarm (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_now     (trip_now),
    .status_wr    (status_wr),
    .status_wdata (status_wdata),
    .alarm_en     (alarm_en),
    .alarm_status (alarm_status),
    .alarm_irq    (alarm_irq)
  );

endmodule

// File: rtl/otp_monitor_chk.sv
module otp_monitor_chk #(
  parameter int unsigned NSENS  = 4,
  parameter int unsigned CODE_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSENS*CODE_W-1:0] sense_code,
  input logic [NSENS-1:0]        sense_vld,
  input logic                    status_wr,
  input logic                    status_wdata,
  input logic                    alarm_en,
  input logic                    eval_fire,
  input logic                    trip_now,
  input logic                    reboot_req,
  input logic                    alarm_status,
  input logic                    alarm_irq
);

  logic any_accept;
  always_comb begin
    any_accept = 1'b0;
    for (int i = 0; i < NSENS; i++) begin
      if (sense_vld[i] && (sense_code[i*CODE_W +: CODE_W] != '0)) any_accept = 1'b1;
    end
  end

  assert_zero_code_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_accept |=> !eval_fire);

  assert_hold_without_eval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_fire |=> $stable(reboot_req));

  assert_reboot_from_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eval_fire |=> (reboot_req == $past(trip_now)));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_status && !(status_wr && status_wdata)) |=> alarm_status);

  assert_status_needs_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_status) |-> reboot_req);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (alarm_en && alarm_status));

endmodule

bind otp_monitor otp_monitor_chk #(.NSENS(NSENS), .CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sense_code   (sense_code),
  .sense_vld    (sense_vld),
  .status_wr    (status_wr),
  .status_wdata (status_wdata),
  .alarm_en     (alarm_en),
  .eval_fire    (eval_fire),
  .trip_now     (trip_now),
  .reboot_req   (reboot_req),
  .alarm_status (alarm_status),
  .alarm_irq    (alarm_irq)
);

// File: tb/otp_monitor_tb.sv
module otp_monitor_tb;

  localparam int NS = 4;
  localparam int CW = 16;
  localparam logic [CW-1:0] CMAX = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS*CW-1:0]  sense_code = '0;
  logic [NS-1:0]     sense_vld = '0;
  logic [19:0]       guard_cfg = '0;
  logic [CW-1:0]     trip_level = '0;
  logic              alarm_en = 1'b0;
  logic              status_wr = 1'b0;
  logic              status_wdata = 1'b0;
  logic              reboot_req, alarm_irq, alarm_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [CW-1:0] m_code [NS];
  logic          m_ok   [NS];
  logic          m_reboot, m_status;
  logic [CW-1:0] t_code [NS];
  logic [NS-1:0] t_vld;

  always #2.5 clk = ~clk;

  otp_monitor #(.NSENS(NS), .CODE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sense_code(sense_code), .sense_vld(sense_vld),
    .guard_cfg(guard_cfg), .trip_level(trip_level), .alarm_en(alarm_en),
    .status_wr(status_wr), .status_wdata(status_wdata),
    .reboot_req(reboot_req), .alarm_irq(alarm_irq), .alarm_status(alarm_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " reboot_req"}, 32'(reboot_req), 32'(m_reboot));
    check({req, " alarm_status"}, 32'(alarm_status), 32'(m_status));
    check({req, " alarm_irq (R8)"}, 32'(alarm_irq), 32'(m_status & alarm_en));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NS; i++) begin m_code[i] = '0; m_ok[i] = 1'b0; end
    m_reboot = 1'b0; m_status = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] mode, input logic [1:0] idx, input logic [13:0] ofs);
    guard_cfg = {idx, mode, 2'b00, ofs};
  endtask

  // drive t_code/t_vld for one cycle; check two edges later
  task automatic step(input string req, input bit clr_mid);
    logic [NS-1:0] fr;
    logic          fire, trip;
    logic [CW-1:0] sel;
    logic [31:0]   s;
    @(negedge clk);
    for (int i = 0; i < NS; i++) sense_code[i*CW +: CW] = t_code[i];
    sense_vld = t_vld;
    fr = '0;
    for (int i = 0; i < NS; i++) begin
      if (t_vld[i] && t_code[i] != 0) begin
        s = 32'(t_code[i]) + 32'(guard_cfg[13:0]);
        m_code[i] = (s > 32'(CMAX)) ? CMAX : s[CW-1:0];
        m_ok[i] = 1'b1;
        fr[i] = 1'b1;
      end
    end
    fire = 1'b0; sel = CMAX;
    if (guard_cfg[17:16] == 2'd1) begin
      fire = |fr;
      for (int i = 0; i < NS; i++) if (m_ok[i] && m_code[i] < sel) sel = m_code[i];
    end else if (guard_cfg[17:16] == 2'd2) begin
      fire = fr[guard_cfg[19:18]];
      sel = m_code[guard_cfg[19:18]];
    end
    trip = fire && (sel <= trip_level);
    @(negedge clk);
    sense_vld = '0;
    if (clr_mid) begin status_wr = 1'b1; status_wdata = 1'b1; end
    if (fire) m_reboot = trip;
    if (trip) m_status = 1'b1;
    else if (clr_mid) m_status = 1'b0;
    @(negedge clk);
    status_wr = 1'b0; status_wdata = 1'b0;
    check_outputs(req);
  endtask

  task automatic write_status(input logic d, input string req);
    @(negedge clk);
    status_wr = 1'b1; status_wdata = d;
    @(negedge clk);
    status_wr = 1'b0; status_wdata = 1'b0;
    if (d) m_status = 1'b0;
    check_outputs(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_outputs("R9 reset");

    // R1: zero codes with valid strobes, threshold at full scale
    alarm_en = 1'b1;
    set_cfg(2'd1, 2'd0, 14'd0);
    trip_level = CMAX;
    for (int i = 0; i < NS; i++) t_code[i] = '0;
    t_vld = 4'hF;
    step("R1 zero codes", 1'b0);

    // R2: saturation keeps the code at full scale, above trip level
    set_cfg(2'd1, 2'd0, 14'h3FFF);
    trip_level = 16'hFFFE;
    t_code[0] = 16'hFFF0; t_vld = 4'b0001;
    step("R2 saturating sum", 1'b0);

    // R2 / R6: plain sum equal to threshold trips
    set_cfg(2'd1, 2'd0, 14'h0010);
    trip_level = 16'h1010;
    t_code[1] = 16'h1000; t_vld = 4'b0010;
    step("R2 R6 sum equals level", 1'b0);

    // R6: one below, latest evaluation clears the request
    trip_level = 16'h100F;
    step("R6 just above level", 1'b0);

    // R5: disabled modes hold the outputs
    trip_level = CMAX;
    set_cfg(2'd0, 2'd0, 14'd0);
    t_code[2] = 16'h0001; t_vld = 4'b0100;
    step("R5 mode 0", 1'b0);
    set_cfg(2'd3, 2'd2, 14'd0);
    step("R5 mode 3", 1'b0);

    // R4: single mode ignores another point
    set_cfg(2'd2, 2'd3, 14'd0);
    t_code[0] = 16'h0002; t_vld = 4'b0001;
    step("R4 other point ignored", 1'b0);

    // R7: write of zero leaves status; trip and clear together keep it set
    set_cfg(2'd1, 2'd0, 14'd0);
    t_code[0] = 16'h0002; t_vld = 4'b0001;
    step("R7 trip sets status", 1'b0);
    write_status(1'b0, "R7 write zero no effect");
    step("R7 trip beats clear", 1'b1);
    write_status(1'b1, "R7 clear");

    // R8: enable off gates only the interrupt line
    alarm_en = 1'b0;
    step("R8 enable off", 1'b0);
    alarm_en = 1'b1;
    @(negedge clk);
    check_outputs("R8 enable on");

    // sweep: R3 R4 R6 over modes, thresholds, offsets and code mixes
    do_reset();
    for (int m = 0; m < 7; m++) begin
      for (int th = 0; th < 3; th++) begin
        alarm_en = (th != 1);
        trip_level = (th == 0) ? 16'h0600 : (th == 1) ? 16'h3000 : 16'hF000;
        write_status(1'b1, "R7 sweep clear");
        for (int of = 0; of < 3; of++) begin
          logic [13:0] ofs;
          ofs = (of == 0) ? 14'd0 : (of == 1) ? 14'h0123 : 14'h3FFF;
          if (m == 0)      set_cfg(2'd1, 2'd0, ofs);
          else if (m < 5)  set_cfg(2'd2, 2'(m - 1), ofs);
          else if (m == 5) set_cfg(2'd0, 2'd1, ofs);
          else             set_cfg(2'd3, 2'd2, ofs);
          for (int p = 0; p < 8; p++) begin
            t_vld = 4'(p * 5 + 3);
            for (int i = 0; i < NS; i++) begin
              case ((p + i) % 4)
                0: t_code[i] = '0;
                1: t_code[i] = 16'(p * 16'h1111 + i * 16'h0321);
                2: t_code[i] = 16'(16'hFFF0 - p * 16'h0400);
                default: t_code[i] = 16'(16'h0500 + p * 16'h0200 + i * 16'h0040);
              endcase
            end
            step((m == 0) ? "R3 R6 sweep" : (m < 5) ? "R4 R6 sweep" : "R5 sweep", 1'b0);
          end
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule